// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block holds the interrupt presentation state of a single processor. Source controllers offer interrupts to it, each offer carrying a 24-bit source number, an 8-bit priority and the index of the offering controller. The block answers every offer it examines. It either takes the offer, or it bounces the offer back to the controller that owns it. A later event can also bounce back an interrupt that the block had already taken. Lower priority values are more favoured, and 0xFF means "none" or "least favoured".

The processor works the block through a small operation port. The operations are: accept the pending interrupt, poll without side effects, write the current processor priority, write the inter-processor-interrupt (IPI) priority, and signal end-of-interrupt. The block drives one level interrupt line towards the processor. Towards the sources it emits a bounce channel, an end-of-interrupt strobe and a resend request.

The IPI is a software-raised interrupt. It competes with external offers for the same single pending slot and carries a reserved source number.

Top module: `irqp_presenter`

## Requirements
- R1: After reset the interrupt line is low. A poll then returns pending word 0x00000000 and IPI priority 0xFF. The pending word holds the processor priority in bits 31:24 and the pending source number in bits 23:0, and source number 0 means nothing is pending.
- R2: An offer whose priority is greater than or equal to the current processor priority is bounced to its own controller index with its own source number, and nothing else changes.
- R3: An offer is also bounced when something is pending with a priority less than or equal to the offered one.
- R4: When an offer is taken, any pending interrupt that has an owning controller is bounced to that controller. The new source, priority and owner are then stored, the line goes high and a one-cycle taken pulse is issued.
- R5: Accept (operation code 0) returns the pending word as it stood before the operation. Afterwards the processor priority equals the old pending priority, the source number is 0, the pending priority is 0xFF, the owner is cleared and the line is low.
- R6: Poll (code 1) returns the pending word and the IPI priority and changes no state.
- R7: Writing the processor priority (code 2, value in bits 7:0) below its old value clears a pending interrupt whose priority is at or above the new value. Clearing lowers the line and bounces the interrupt to its owner. A pending IPI has no owner and is dropped without a bounce.
- R8: Writing the processor priority at or above its old value while nothing is pending issues a resend request. Before that, if the IPI priority is below the new processor priority, the IPI is made pending.
- R9: Writing the IPI priority (code 3, bits 7:0) stores it. If the value is below the processor priority and nothing is pending at a priority at or below it, any owned pending interrupt is bounced, source number IPI_SRC (default 2) becomes pending at the IPI priority with no owner, and the line goes high.
- R10: End-of-interrupt (code 4) loads the processor priority from bits 31:24 and pulses the end-of-interrupt strobe carrying bits 23:0. If nothing is pending, it then performs the resend of R8, using the new processor priority for the IPI test.
- R11: While an operation is presented, offer_hold is high in the same cycle and the offer is not examined: it is neither taken nor bounced.
- R12: Operation codes 5 to 7 have no effect on state or outputs.
- R13: Every result and strobe appears in the cycle after the clock edge that samples the stimulus, and all strobes are one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offer_valid | input | 1 | An offer is presented |
| offer_src | input | 24 | Offered source number (nonzero) |
| offer_prio | input | 8 | Offered priority |
| offer_ctl | input | OWN_W | Index of the offering source controller |
| offer_hold | output | 1 | Offer not examined this cycle; keep it presented |
| offer_taken | output | 1 | Pulse: the examined offer was taken |
| bounce_valid | output | 1 | Pulse: an interrupt is handed back |
| bounce_src | output | 24 | Source number handed back |
| bounce_ctl | output | OWN_W | Controller that receives the bounce |
| op_valid | input | 1 | A processor operation is presented |
| op_code | input | 3 | 0 accept, 1 poll, 2 processor priority, 3 IPI priority, 4 end-of-interrupt |
| op_wdata | input | 32 | Operand of write operations |
| rd_valid | output | 1 | Pulse: read data valid |
| rd_word | output | 32 | Pending word returned by accept or poll |
| rd_ipi_prio | output | 8 | IPI priority returned by accept or poll |
| done_valid | output | 1 | Pulse: end-of-interrupt to the sources |
| done_src | output | 24 | Source number of the end-of-interrupt |
| resend_req | output | 1 | Pulse: sources should re-offer bounced interrupts |
| cpu_irq | output | 1 | Level interrupt line to the processor |

## Verification
offer_hold is combinational and is due in the same cycle as the operation that raises it. Every other output comes from a register. The bounce, taken, end-of-interrupt, resend and read pulses therefore show up exactly one clock after the rising edge that samples the stimulus, and so do the line level and every state change. The bench drives each stimulus on a falling edge and checks offer_hold shortly after driving. It then waits for the next rising edge and compares every output 1 ns later against a bench model stepped once for that stimulus. Each stimulus therefore owns exactly one result window, and a pulse that comes late or lasts too long fails the next window.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [2:0] {
    OP_ACCEPT   = 3'd0,
    OP_POLL     = 3'd1,
    OP_CPU_PRIO = 3'd2,
    OP_IPI_PRIO = 3'd3,
    OP_EOI      = 3'd4
  } irqp_op_e;
endpackage

// File: rtl/irqp_offer_judge.sv
module irqp_offer_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              slot_busy,
  input  logic [PRIO_W-1:0] slot_prio,
  input  logic [PRIO_W-1:0] cand_prio,
  output logic              take
);
  // favoured over the processor and strictly better than what sits in the slot
  always_comb begin
    take = (cand_prio < cur_prio) && !(slot_busy && (slot_prio <= cand_prio));
  end
endmodule

// File: rtl/irqp_ipi_judge.sv
module irqp_ipi_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              slot_busy,
  input  logic [PRIO_W-1:0] slot_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              fire
);
  always_comb begin
    fire = (ipi_prio < cur_prio) && !(slot_busy && (slot_prio <= ipi_prio));
  end
endmodule

// File: rtl/irqp_presenter.sv
module irqp_presenter
  import irqp_pkg::*;
#(
  parameter int                N_CTL   = 4,
  parameter logic [SRC_W-1:0]  IPI_SRC = 24'd2,
  localparam int               OWN_W   = (N_CTL > 1) ? $clog2(N_CTL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [OWN_W-1:0]  offer_ctl,
  output logic              offer_hold,
  output logic              offer_taken,
  output logic              bounce_valid,
  output logic [SRC_W-1:0]  bounce_src,
  output logic [OWN_W-1:0]  bounce_ctl,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] op_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic [PRIO_W-1:0] rd_ipi_prio,
  output logic              done_valid,
  output logic [SRC_W-1:0]  done_src,
  output logic              resend_req,
  output logic              cpu_irq
);
  // architectural state
  logic [PRIO_W-1:0] q_cppr, n_cppr;
  logic [SRC_W-1:0]  q_src,  n_src;
  logic [PRIO_W-1:0] q_pp,   n_pp;
  logic [PRIO_W-1:0] q_ipi,  n_ipi;
  logic [OWN_W-1:0]  q_own,  n_own;
  logic              q_own_v, n_own_v;
  logic              q_irq,  n_irq;
  logic              state_en;

  // strobe next values
  logic              n_taken, n_bounce, n_rd, n_done, n_resend;
  logic [SRC_W-1:0]  n_bounce_src, n_done_src;
  logic [OWN_W-1:0]  n_bounce_ctl;
  logic [WORD_W-1:0] n_rd_word;
  logic [PRIO_W-1:0] n_rd_ipi;

  irqp_op_e          op;
  logic              busy;
  logic              offer_ok, ipi_fire;
  logic [PRIO_W-1:0] ij_cur, ij_ipi;
  logic [PRIO_W-1:0] w_lo, w_hi;

  assign op         = irqp_op_e'(op_code);
  assign busy       = (q_src != '0);
  assign w_lo       = op_wdata[PRIO_W-1:0];
  assign w_hi       = op_wdata[WORD_W-1:SRC_W];
  assign offer_hold = op_valid;
  assign state_en   = op_valid | offer_valid;

  // one IPI judge shared by the IPI write and the resend paths
  always_comb begin
    ij_cur = q_cppr;
    ij_ipi = q_ipi;
    if (op_valid) begin
      case (op)
        OP_CPU_PRIO: ij_cur = w_lo;
        OP_EOI:      ij_cur = w_hi;
        OP_IPI_PRIO: ij_ipi = w_lo;
        default:     ;
      endcase
    end
  end

  irqp_ipi_judge #(.PRIO_W(PRIO_W)) u_ipi_judge (
    .cur_prio  (ij_cur),
    .slot_busy (busy),
    .slot_prio (q_pp),
    .ipi_prio  (ij_ipi),
    .fire      (ipi_fire)
  );

  irqp_offer_judge #(.PRIO_W(PRIO_W)) u_offer_judge (
    .cur_prio  (q_cppr),
    .slot_busy (busy),
    .slot_prio (q_pp),
    .cand_prio (offer_prio),
    .take      (offer_ok)
  );

  // next-state logic
  always_comb begin
    n_cppr  = q_cppr;
    n_src   = q_src;
    n_pp    = q_pp;
    n_ipi   = q_ipi;
    n_own   = q_own;
    n_own_v = q_own_v;
    n_irq   = q_irq;
    n_taken = 1'b0;
    n_bounce = 1'b0;
    n_bounce_src = '0;
    n_bounce_ctl = '0;
    n_rd      = 1'b0;
    n_rd_word = '0;
    n_rd_ipi  = '0;
    n_done    = 1'b0;
    n_done_src = '0;
    n_resend  = 1'b0;

    if (op_valid) begin
      case (op)
        OP_ACCEPT: begin
          n_rd      = 1'b1;
          n_rd_word = {q_cppr, q_src};
          n_rd_ipi  = q_ipi;
          n_cppr    = q_pp;
          n_src     = '0;
          n_pp      = PRIO_NONE;
          n_own_v   = 1'b0;
          n_irq     = 1'b0;
        end
        OP_POLL: begin
          n_rd      = 1'b1;
          n_rd_word = {q_cppr, q_src};
          n_rd_ipi  = q_ipi;
        end
        OP_CPU_PRIO: begin
          n_cppr = w_lo;
          if (w_lo < q_cppr) begin
            if (busy && (w_lo <= q_pp)) begin
              if (q_own_v) begin
                n_bounce     = 1'b1;
                n_bounce_src = q_src;
                n_bounce_ctl = q_own;
              end
              n_src   = '0;
              n_pp    = PRIO_NONE;
              n_own_v = 1'b0;
              n_irq   = 1'b0;
            end
          end else if (!busy) begin
            n_resend = 1'b1;
            if (ipi_fire) begin
              n_src   = IPI_SRC;
              n_pp    = ij_ipi;
              n_own_v = 1'b0;
              n_irq   = 1'b1;
            end
          end
        end
        OP_IPI_PRIO: begin
          n_ipi = w_lo;
          if (ipi_fire) begin
            if (busy && q_own_v) begin
              n_bounce     = 1'b1;
              n_bounce_src = q_src;
              n_bounce_ctl = q_own;
            end
            n_src   = IPI_SRC;
            n_pp    = ij_ipi;
            n_own_v = 1'b0;
            n_irq   = 1'b1;
          end
        end
        OP_EOI: begin
          n_cppr     = w_hi;
          n_done     = 1'b1;
          n_done_src = op_wdata[SRC_W-1:0];
          if (!busy) begin
            n_resend = 1'b1;
            if (ipi_fire) begin
              n_src   = IPI_SRC;
              n_pp    = ij_ipi;
              n_own_v = 1'b0;
              n_irq   = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (offer_valid) begin
      if (offer_ok) begin
        if (busy && q_own_v) begin
          n_bounce     = 1'b1;
          n_bounce_src = q_src;
          n_bounce_ctl = q_own;
        end
        n_src   = offer_src;
        n_pp    = offer_prio;
        n_own   = offer_ctl;
        n_own_v = 1'b1;
        n_irq   = 1'b1;
        n_taken = 1'b1;
      end else begin
        n_bounce     = 1'b1;
        n_bounce_src = offer_src;
        n_bounce_ctl = offer_ctl;
      end
    end
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cppr  <= '0;
      q_src   <= '0;
      q_pp    <= PRIO_NONE;
      q_ipi   <= PRIO_NONE;
      q_own   <= '0;
      q_own_v <= 1'b0;
      q_irq   <= 1'b0;
    end else if (state_en) begin
      q_cppr  <= n_cppr;
      q_src   <= n_src;
      q_pp    <= n_pp;
      q_ipi   <= n_ipi;
      q_own   <= n_own;
      q_own_v <= n_own_v;
      q_irq   <= n_irq;
    end
  end

  // strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_taken  <= 1'b0;
      bounce_valid <= 1'b0;
      bounce_src   <= '0;
      bounce_ctl   <= '0;
      rd_valid     <= 1'b0;
      rd_word      <= '0;
      rd_ipi_prio  <= '0;
      done_valid   <= 1'b0;
      done_src     <= '0;
      resend_req   <= 1'b0;
    end else begin
      offer_taken  <= n_taken;
      bounce_valid <= n_bounce;
      bounce_src   <= n_bounce_src;
      bounce_ctl   <= n_bounce_ctl;
      rd_valid     <= n_rd;
      rd_word      <= n_rd_word;
      rd_ipi_prio  <= n_rd_ipi;
      done_valid   <= n_done;
      done_src     <= n_done_src;
      resend_req   <= n_resend;
    end
  end

  assign cpu_irq = q_irq;
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int OWN_W = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic        offer_taken,
  input logic        bounce_valid,
  input logic        rd_valid,
  input logic        done_valid,
  input logic        resend_req,
  input logic        cpu_irq,
  input logic [23:0] q_src,
  input logic [7:0]  q_cppr,
  input logic [7:0]  q_pp,
  input logic [7:0]  q_ipi
);
  // R4: the line is high exactly while a source number is pending
  p_line_follows_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (q_src != 24'd0));

  // R4: a taken pulse comes with a raised line
  p_taken_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    offer_taken |-> cpu_irq);

  // R5: accept empties the slot and lowers the line
  p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0) |=> (rd_valid && !cpu_irq && q_src == 24'd0 && q_pp == 8'hFF));

  // R6: poll leaves every state register alone
  p_poll_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1) |=> ($stable(q_src) && $stable(q_cppr) && $stable(q_pp)
                                       && $stable(q_ipi) && !bounce_valid && !offer_taken));

  // R10: an end-of-interrupt never hands anything back
  p_eoi_no_bounce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !bounce_valid);

  // R11: an offer is never taken while an operation holds it
  p_hold_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !offer_taken);

  // R12: codes above 4 do nothing
  p_unused_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 3'd4) |=> ($stable(q_src) && $stable(q_cppr) && $stable(q_pp)
                                      && $stable(q_ipi) && !rd_valid && !done_valid
                                      && !resend_req && !bounce_valid));
endmodule

bind irqp_presenter irqp_checker #(.OWN_W(OWN_W)) u_irqp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .offer_taken  (offer_taken),
  .bounce_valid (bounce_valid),
  .rd_valid     (rd_valid),
  .done_valid   (done_valid),
  .resend_req   (resend_req),
  .cpu_irq      (cpu_irq),
  .q_src        (q_src),
  .q_cppr       (q_cppr),
  .q_pp         (q_pp),
  .q_ipi        (q_ipi)
);

// File: tb/irqp_presenter_bench.sv
`timescale 1ns/1ps
module irqp_presenter_bench;
  localparam int OWN_W = 2;
  localparam logic [23:0] IPI = 24'd2;

  logic clk = 1'b0;
  logic rst_n;
  logic offer_valid;
  logic [23:0] offer_src;
  logic [7:0]  offer_prio;
  logic [OWN_W-1:0] offer_ctl;
  logic offer_hold, offer_taken, bounce_valid;
  logic [23:0] bounce_src;
  logic [OWN_W-1:0] bounce_ctl;
  logic op_valid;
  logic [2:0] op_code;
  logic [31:0] op_wdata;
  logic rd_valid;
  logic [31:0] rd_word;
  logic [7:0] rd_ipi_prio;
  logic done_valid;
  logic [23:0] done_src;
  logic resend_req, cpu_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irqp_presenter #(.N_CTL(4), .IPI_SRC(IPI)) u_irqp_presenter (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_ctl(offer_ctl), .offer_hold(offer_hold), .offer_taken(offer_taken),
    .bounce_valid(bounce_valid), .bounce_src(bounce_src), .bounce_ctl(bounce_ctl),
    .op_valid(op_valid), .op_code(op_code), .op_wdata(op_wdata),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_ipi_prio(rd_ipi_prio),
    .done_valid(done_valid), .done_src(done_src), .resend_req(resend_req),
    .cpu_irq(cpu_irq)
  );

  // bench model state
  logic [7:0]  m_cppr, m_pp, m_ipi;
  logic [23:0] m_src;
  logic [OWN_W-1:0] m_own;
  bit m_ownv, m_irq;
  // expected pulses
  bit e_take, e_rej, e_rd, e_eoi, e_rs;
  logic [23:0] e_rej_src, e_eoi_src;
  logic [OWN_W-1:0] e_rej_ctl;
  logic [31:0] e_rdw;
  logic [7:0]  e_rdi;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic m_bounce(input logic [23:0] s, input logic [OWN_W-1:0] c);
    e_rej = 1; e_rej_src = s; e_rej_ctl = c;
  endtask

  task automatic m_ipi_check();
    if (m_src != 0 && m_pp <= m_ipi) return;
    if (m_src != 0 && m_ownv) m_bounce(m_src, m_own);
    m_src = IPI; m_pp = m_ipi; m_ownv = 0; m_irq = 1;
  endtask

  task automatic m_resend();
    if (m_ipi < m_cppr) m_ipi_check();
    e_rs = 1;
  endtask

  task automatic m_step(input bit ov, input logic [2:0] op, input logic [31:0] w,
                        input bit fv, input logic [23:0] s, input logic [7:0] p,
                        input logic [OWN_W-1:0] c);
    logic [7:0] old;
    e_take = 0; e_rej = 0; e_rd = 0; e_eoi = 0; e_rs = 0;
    if (ov) begin
      case (op)
        3'd0: begin
          e_rd = 1; e_rdw = {m_cppr, m_src}; e_rdi = m_ipi;
          m_cppr = m_pp; m_src = 0; m_pp = 8'hFF; m_ownv = 0; m_irq = 0;
        end
        3'd1: begin e_rd = 1; e_rdw = {m_cppr, m_src}; e_rdi = m_ipi; end
        3'd2: begin
          old = m_cppr; m_cppr = w[7:0];
          if (w[7:0] < old) begin
            if (m_src != 0 && w[7:0] <= m_pp) begin
              if (m_ownv) m_bounce(m_src, m_own);
              m_src = 0; m_pp = 8'hFF; m_ownv = 0; m_irq = 0;
            end
          end else if (m_src == 0) m_resend();
        end
        3'd3: begin m_ipi = w[7:0]; if (m_ipi < m_cppr) m_ipi_check(); end
        3'd4: begin
          m_cppr = w[31:24]; e_eoi = 1; e_eoi_src = w[23:0];
          if (m_src == 0) m_resend();
        end
        default: ;
      endcase
    end else if (fv) begin
      if (p >= m_cppr || (m_src != 0 && m_pp <= p)) m_bounce(s, c);
      else begin
        if (m_src != 0 && m_ownv) m_bounce(m_src, m_own);
        m_src = s; m_pp = p; m_own = c; m_ownv = 1; m_irq = 1; e_take = 1;
      end
    end
  endtask

  // one stimulus: drive at the falling edge, compare 1 ns after the next rising edge
  task automatic step(input string tag, input bit ov, input logic [2:0] op, input logic [31:0] w,
                      input bit fv, input logic [23:0] s, input logic [7:0] p,
                      input logic [OWN_W-1:0] c);
    @(negedge clk);
    op_valid = ov; op_code = op; op_wdata = w;
    offer_valid = fv; offer_src = s; offer_prio = p; offer_ctl = c;
    #0.5;
    chk("R11", "offer_hold", {31'd0, offer_hold}, {31'd0, ov});
    m_step(ov, op, w, fv, s, p, c);
    @(posedge clk); #1;
    chk(tag, "cpu_irq", {31'd0, cpu_irq}, {31'd0, m_irq});
    chk(tag, "offer_taken", {31'd0, offer_taken}, {31'd0, e_take});
    chk(tag, "bounce_valid", {31'd0, bounce_valid}, {31'd0, e_rej});
    if (e_rej) begin
      chk(tag, "bounce_src", {8'd0, bounce_src}, {8'd0, e_rej_src});
      chk(tag, "bounce_ctl", {30'd0, bounce_ctl}, {30'd0, e_rej_ctl});
    end
    chk(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, e_rd});
    if (e_rd) begin
      chk(tag, "rd_word", rd_word, e_rdw);
      chk(tag, "rd_ipi_prio", {24'd0, rd_ipi_prio}, {24'd0, e_rdi});
    end
    chk(tag, "done_valid", {31'd0, done_valid}, {31'd0, e_eoi});
    if (e_eoi) chk(tag, "done_src", {8'd0, done_src}, {8'd0, e_eoi_src});
    chk(tag, "resend_req", {31'd0, resend_req}, {31'd0, e_rs});
    @(negedge clk);
    op_valid = 0; offer_valid = 0;
  endtask

  task automatic op_(input string tag, input logic [2:0] op, input logic [31:0] w);
    step(tag, 1, op, w, 0, 24'd0, 8'd0, '0);
  endtask

  task automatic offer(input string tag, input logic [23:0] s, input logic [7:0] p, input logic [OWN_W-1:0] c);
    step(tag, 0, 3'd0, 32'd0, 1, s, p, c);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R13 watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 0; op_valid = 0; op_code = 0; op_wdata = 0;
    offer_valid = 0; offer_src = 0; offer_prio = 0; offer_ctl = 0;
    m_cppr = 0; m_src = 0; m_pp = 8'hFF; m_ipi = 8'hFF; m_own = 0; m_ownv = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cpu_irq at reset", {31'd0, cpu_irq}, 32'd0);
    rst_n = 1;
    op_("R1", 3'd1, 32'd0);                       // poll: 0 / FF
    offer("R2", 24'h11, 8'h04, 2'd3);             // cppr 0: bounced
    op_("R8", 3'd2, 32'h0000_00FF);               // raise cppr, nothing pending: resend
    offer("R4", 24'h10, 8'h05, 2'd1);             // taken
    offer("R3", 24'h20, 8'h05, 2'd2);             // equal to pending: bounced
    offer("R4", 24'h30, 8'h03, 2'd2);             // displaces 0x10 back to ctl 1
    op_("R5", 3'd0, 32'd0);                       // returns FF000030, cppr becomes 3
    offer("R2", 24'h40, 8'h03, 2'd0);             // equal to cppr: bounced
    op_("R9", 3'd3, 32'h0000_0001);               // IPI at priority 1
    op_("R6", 3'd1, 32'd0);                       // poll 03000002 / 01
    op_("R6", 3'd1, 32'd0);                       // poll again, same
    op_("R7", 3'd2, 32'h0000_0000);               // drop IPI, no bounce
    op_("R10", 3'd4, 32'hFF00_0030);              // eoi, then resend raises IPI
    op_("R12", 3'd6, 32'hFFFF_FFFF);              // unused code
    step("R11", 1, 3'd1, 32'd0, 1, 24'h55, 8'h00, 2'd1); // poll collides with offer
    op_("R9", 3'd3, 32'h0000_00FF);               // IPI priority back to none
    op_("R5", 3'd0, 32'd0);
    op_("R10", 3'd4, 32'h0800_0002);
    offer("R4", 24'h77, 8'h02, 2'd2);
    op_("R9", 3'd3, 32'h0000_0001);               // IPI displaces owned 0x77
    op_("R7", 3'd2, 32'h0000_0001);               // at IPI priority: dropped
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      int unsigned k = $urandom_range(0, 9);
      logic [7:0] rp = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 12));
      logic [23:0] rs = 24'($urandom_range(1, 200));
      logic [OWN_W-1:0] rc = OWN_W'($urandom_range(0, 3));
      case (k)
        0: op_("R5", 3'd0, 32'd0);
        1: op_("R6", 3'd1, 32'd0);
        2: op_("R7", 3'd2, {24'd0, rp});
        3: op_("R9", 3'd3, {24'd0, rp});
        4: op_("R10", 3'd4, {rp, rs});
        5: op_("R12", 3'($urandom_range(5, 7)), $urandom);
        6: step("R11", 1, 3'($urandom_range(0, 4)), {rp, rs}, 1, rs, rp, rc);
        default: offer("R4", rs, rp, rc);
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule